// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block turns a four-coil stepper motor at a steady rate. It plays four full-step coil patterns in a fixed cycle and holds each one for a set dwell time. The patterns are 0x5, 0x6, 0xA and 0x9, with bit 3 down to bit 0 driving the four coil lines. Timing is open loop: only elapsed clock cycles decide when the pattern moves on, and no motor status is read back.

The dwell is one millisecond by default. The parameter `CYCLES_PER_MS` gives the number of clock cycles in a millisecond, and `DWELL_MS` gives the number of milliseconds each pattern is held. An enable input pauses and resumes the motion without losing the time already spent in the current dwell. A direction input walks the same cycle backwards. A one-cycle strobe marks every change of pattern, so that the step rate can be measured outside the block.

Top module: `stepper_phase_sequencer`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, `coilDrive` is 0x5 and `stepPulse` is low. After reset the first change of pattern comes only after a full dwell.
- R2: With `direction` low, each change of pattern follows the cycle 0x5 → 0x6 → 0xA → 0x9 → 0x5, repeating for as long as the block is enabled.
- R3: Each pattern stays on `coilDrive` for exactly `CYCLES_PER_MS*DWELL_MS` clock edges at which `enable` is high, counted from the edge that set it.
- R4: A clock edge with `enable` low changes neither `coilDrive` nor the elapsed dwell. When `enable` goes high again, the pattern changes after the remaining part of the dwell.
- R5: With `direction` high, each change of pattern follows the cycle 0x5 → 0x9 → 0xA → 0x6 → 0x5.
- R6: `stepPulse` is high for exactly the one cycle in which `coilDrive` first shows a new pattern, and low in every other cycle.
- R7: A change of `direction` partway through a dwell does not restart the dwell. The direction is taken at the edge where the pattern changes.
- R8: `coilDrive` always holds one of the four values 0x5, 0x6, 0xA or 0x9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the dwell timer while high; hold everything while low |
| direction | input | 1 | 0 walks the cycle forwards, 1 walks it backwards |
| coilDrive | output | 4 | Coil pattern, bit 3 down to bit 0 |
| stepPulse | output | 1 | One-cycle strobe in the first cycle of each new pattern |

## Verification
The hardest cases involve inputs that change partway through a dwell. One is a pause that falls between two steps, which must leave the elapsed count untouched. Another is a direction flip a few cycles before a step, which must neither lengthen nor shorten the dwell. The stimulus uses a short dwell and changes `enable` and `direction` at odd offsets from the last strobe, including the cycle just before a step is due. It also applies a reset in the middle of a dwell. A cycle-by-cycle reference model predicts `coilDrive` and `stepPulse` through all of these cases.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef logic [3:0] coil_t;
  typedef logic [1:0] phase_t;

  // Strobes from the dwell control to the phase datapath
  typedef struct packed {
    logic advance;   // move to the next pattern at this edge
    logic reverse;   // walk backwards when advancing
  } seq_ctrl_t;

  localparam int unsigned NUM_PHASES = 4;

  // Phase index to coil pattern; adjacent indices differ by one coil swap
  function automatic coil_t phasePattern(input phase_t idx);
    coil_t pat;
    case (idx)
      2'd0:    pat = 4'h5;
      2'd1:    pat = 4'h6;
      2'd2:    pat = 4'hA;
      default: pat = 4'h9;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/stepper_dwell_ctrl.sv
module stepper_dwell_ctrl
  import stepper_pkg::*;
#(
  parameter int unsigned DWELL_CYCLES = 50000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      direction,
  output seq_ctrl_t ctrl
);

  localparam int unsigned CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;

  logic atLast;

  generate
    if (DWELL_CYCLES <= 1) begin : g_noDwell
      // Every enabled edge is a step
      assign atLast = 1'b1;
    end else begin : g_dwell
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);
      logic [CNT_W-1:0] dwellCnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          dwellCnt <= '0;
        end else if (enable) begin
          if (dwellCnt == LAST) dwellCnt <= '0;
          else                  dwellCnt <= dwellCnt + 1'b1;
        end
      end

      assign atLast = (dwellCnt == LAST);
    end
  endgenerate

  always_comb begin
    ctrl.advance = enable & atLast & ~rst;
    ctrl.reverse = direction;
  end

endmodule

// File: rtl/stepper_phase_path.sv
module stepper_phase_path
  import stepper_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  seq_ctrl_t ctrl,
  output coil_t     coilDrive,
  output logic      stepPulse
);

  phase_t phaseIdx;
  phase_t nextIdx;

  always_comb begin
    if (ctrl.reverse) nextIdx = phaseIdx - 2'd1;
    else              nextIdx = phaseIdx + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseIdx  <= '0;
      coilDrive <= phasePattern(2'd0);
      stepPulse <= 1'b0;
    end else begin
      stepPulse <= ctrl.advance;
      if (ctrl.advance) begin
        phaseIdx  <= nextIdx;
        coilDrive <= phasePattern(nextIdx);
      end
    end
  end

endmodule

// File: rtl/stepper_phase_sequencer.sv
module stepper_phase_sequencer
  import stepper_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 50000,
  parameter int unsigned DWELL_MS      = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       direction,
  output logic [3:0] coilDrive,
  output logic       stepPulse
);

  localparam int unsigned DWELL_CYCLES = CYCLES_PER_MS * DWELL_MS;

  seq_ctrl_t ctrl;

  stepper_dwell_ctrl #(
    .DWELL_CYCLES(DWELL_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .direction (direction),
    .ctrl      (ctrl)
  );

  stepper_phase_path u_path (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .coilDrive (coilDrive),
    .stepPulse (stepPulse)
  );

endmodule

// File: rtl/stepper_seq_checker.sv
module stepper_seq_checker #(
  parameter int unsigned DWELL_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       direction,
  input logic [3:0] coilDrive,
  input logic       stepPulse
);

  localparam int unsigned CW = $clog2(DWELL_CYCLES + 2) + 1;

  // Enabled edges since the edge that set the current pattern
  logic [CW-1:0] chkCnt;

  always_ff @(posedge clk) begin
    if (rst) chkCnt <= '0;
    else     chkCnt <= (stepPulse ? CW'(0) : chkCnt) + CW'(enable);
  end

  function automatic logic [3:0] fwdOf(input logic [3:0] c);
    case (c)
      4'h5:    return 4'h6;
      4'h6:    return 4'hA;
      4'hA:    return 4'h9;
      default: return 4'h5;
    endcase
  endfunction

  function automatic logic [3:0] revOf(input logic [3:0] c);
    case (c)
      4'h5:    return 4'h9;
      4'h9:    return 4'hA;
      4'hA:    return 4'h6;
      default: return 4'h5;
    endcase
  endfunction

  a_r8_legal_pattern: assert property (@(posedge clk) disable iff (rst)
    (coilDrive == 4'h5 || coilDrive == 4'h6 || coilDrive == 4'hA || coilDrive == 4'h9));

  a_r6_pulse_marks_change: assert property (@(posedge clk) disable iff (rst)
    stepPulse != $stable(coilDrive));

  a_r2_forward_order: assert property (@(posedge clk) disable iff (rst)
    (stepPulse && !$past(direction)) |-> coilDrive == fwdOf($past(coilDrive)));

  a_r5_reverse_order: assert property (@(posedge clk) disable iff (rst)
    (stepPulse && $past(direction)) |-> coilDrive == revOf($past(coilDrive)));

  a_r4_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> ($stable(coilDrive) && !stepPulse));

  // R3 and R7: dwell length is exact regardless of direction changes
  a_r3_dwell_exact: assert property (@(posedge clk) disable iff (rst)
    stepPulse |-> chkCnt == CW'(DWELL_CYCLES));

  a_r3_dwell_bound: assert property (@(posedge clk) disable iff (rst)
    chkCnt <= CW'(DWELL_CYCLES));

endmodule

bind stepper_phase_sequencer stepper_seq_checker #(
  .DWELL_CYCLES(DWELL_CYCLES)
) u_seqChk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .direction (direction),
  .coilDrive (coilDrive),
  .stepPulse (stepPulse)
);

// File: tb/sim_stepper_phase_sequencer.sv
`timescale 1ns/1ps
module sim_stepper_phase_sequencer;

  localparam int CPM   = 5;
  localparam int DMS   = 1;
  localparam int DWELL = CPM * DMS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       direction = 1'b0;
  logic [3:0] coilDrive;
  logic       stepPulse;

  always #2 clk = ~clk;   // 250 MHz

  stepper_phase_sequencer #(.CYCLES_PER_MS(CPM), .DWELL_MS(DMS)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .direction(direction),
    .coilDrive(coilDrive), .stepPulse(stepPulse)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // Reference model: phase position, elapsed dwell, strobe
  logic [3:0] patQ [$] = '{4'h5, 4'h6, 4'hA, 4'h9};
  int mIdx = 0;
  int mCnt = 0;
  bit mPulse = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      mIdx = 0; mCnt = 0; mPulse = 1'b0;
    end else begin
      mPulse = 1'b0;
      if (enable) begin
        mCnt++;
        if (mCnt == DWELL) begin
          mCnt = 0;
          mIdx = direction ? (mIdx + 3) % 4 : (mIdx + 1) % 4;
          mPulse = 1'b1;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      check(curReq, coilDrive, patQ[mIdx], "coilDrive");
      check((curReq == "R1") ? "R1" : "R6", stepPulse, mPulse, "stepPulse");
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : stim
    int gap;
    int lastStep;
    // R1: reset state
    run(3);
    curReq = "R1";
    check("R1", coilDrive, 4'h5, "reset coil");
    check("R1", stepPulse, 0, "reset pulse");
    rst = 1'b0;
    enable = 1'b1;
    // R1/R3: first step only after a full dwell
    run(DWELL - 1);
    check("R1", coilDrive, 4'h5, "no early step");
    run(1);
    check("R3", stepPulse, 1, "first step after dwell");
    check("R2", coilDrive, 4'h6, "first forward step");
    // R2/R3: forward run, measure dwell spacing
    curReq = "R2";
    lastStep = 0;
    gap = 0;
    for (int i = 0; i < 4 * DWELL; i++) begin
      run(1);
      gap++;
      if (stepPulse) begin
        check("R3", gap, DWELL, "dwell length");
        gap = 0;
      end
    end
    // R4: pause mid-dwell, then resume
    curReq = "R4";
    run(2);
    enable = 1'b0;
    run(7);
    enable = 1'b1;
    run(1);
    enable = 1'b0;
    run(3);
    enable = 1'b1;
    run(2 * DWELL);
    // R5: reverse walk
    curReq = "R5";
    direction = 1'b1;
    run(6 * DWELL);
    // R7: flip direction just before a step and mid-dwell
    curReq = "R7";
    for (int k = 0; k < 6; k++) begin
      run(k % 3 + 1);
      direction = ~direction;
    end
    run(3 * DWELL);
    // R4: pause exactly when a step is due
    curReq = "R4";
    while (mCnt != DWELL - 1) run(1);
    enable = 1'b0;
    run(4);
    enable = 1'b1;
    run(2);
    // R1: reset in the middle of a dwell
    curReq = "R1";
    run(2);
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    run(DWELL + 2);
    curReq = "R8";
    direction = 1'b0;
    run(8 * DWELL);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    done = 1'b1;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule